// File: doc/BRIEF.md
# Packed Saturating Add/Subtract ALU

This block is a SIMD integer adder for 64-bit operand registers. A width code splits both operands into lanes of 8, 16, 32 or 64 bits. Each lane then computes on its own, with no carry or borrow crossing a lane boundary. The lanes are joined back into one 64-bit result.

Per operation, the caller picks one of three operations: add, subtract, or a rounding average. For add and subtract, a saturation enable selects clamping instead of wraparound. A signedness bit then selects the clamp limits: the two's-complement bounds when signed, or zero and all ones when unsigned.

Each accepted operation is registered. Its result appears on the output one clock after the request, together with a one-cycle valid pulse. The result register keeps its value until the next accepted request or a reset.

Top module: `pal_top`

## Requirements
- R1: When `in_sat` is 0, add (`in_op`=0) gives a+b modulo 2^W in each lane and subtract (`in_op`=1) gives a−b modulo 2^W, whatever `in_signed` is.
- R2: `in_width` selects the lane width W: 0=8, 1=16, 2=32, 3=64. Lane i occupies bits [(i+1)·W−1 : i·W], there are 64/W lanes, and no lane's result depends on another lane's operands.
- R3: Signed saturating add (`in_sat`=1, `in_signed`=1, `in_op`=0): when both operand signs match and the wrapped sign differs, the lane becomes the most positive value if the operands were non-negative, else the most negative value.
- R4: Signed saturating subtract (`in_op`=1) clamps the same way when a true difference lies outside the signed W-bit range.
- R5: Unsigned saturating add gives all ones in a lane whose sum carries out of bit W−1.
- R6: Unsigned saturating subtract gives zero in a lane where b is larger than a.
- R7: Average (`in_op`=2) gives floor((a+b+1)/2) per lane on unsigned values, with no loss of the carry, and ignores `in_sat` and `in_signed`.
- R8: The reserved opcode 3 gives an all-zero result.
- R9: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. `out_result` then shows that request's result and holds it while no request arrives.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_result` to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe, one operation per cycle |
| in_op | input | 2 | 0 add, 1 subtract, 2 average, 3 reserved |
| in_width | input | 2 | Lane width code: 0=8, 1=16, 2=32, 3=64 bits |
| in_sat | input | 1 | Saturation enable for add and subtract |
| in_signed | input | 1 | Signed clamp limits when saturating |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand (subtrahend) |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 64 | Registered packed result |

## Verification
The only state is the result register and its valid flag, so a wrong internal value shows at the ports in the cycle right after the request that caused it. A lane that picks the wrong clamp limit, or leaks a carry into its neighbour, gives a wrong lane field at once. Extreme operands at every width expose these errors: sign-boundary values, all ones, zero, and values one step past a limit. The cycle-level model in the bench also catches a stale or dropped valid pulse. It compares every clock, including idle ones, so a result that changes without a request is caught within a cycle.

// File: rtl/pal_pkg.sv
package pal_pkg;

   typedef enum logic [1:0] {
      PAL_ADD = 2'd0,
      PAL_SUB = 2'd1,
      PAL_AVG = 2'd2,
      PAL_RSV = 2'd3
   } pal_op_e;

   typedef enum logic [1:0] {
      PAL_W8  = 2'd0,
      PAL_W16 = 2'd1,
      PAL_W32 = 2'd2,
      PAL_W64 = 2'd3
   } pal_width_e;

   typedef struct packed {
      pal_op_e op;
      logic    sat;
      logic    sgn;
   } pal_ctrl_t;

   localparam int PAL_NUM_WIDTHS = 4;
   localparam int PAL_MIN_LANE_W = 8;

endpackage

// File: rtl/pal_lane.sv
module pal_lane
   import pal_pkg::*;
#(
   parameter int W = 8
) (
   input  pal_ctrl_t      ctrl,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   res
);

   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] SMAX = ~SMIN;
   localparam logic [W-1:0] UMAX = '1;

   logic [W:0]   sum_ext;
   logic [W:0]   dif_ext;
   logic [W-1:0] avg_val;
   logic         sovf_add;
   logic         sovf_sub;

   // one extra bit keeps the carry out / borrow out of each lane
   assign sum_ext = {1'b0, a} + {1'b0, b};
   assign dif_ext = {1'b0, a} - {1'b0, b};

   // halves plus a rounding term cannot exceed W bits
   assign avg_val = {1'b0, a[W-1:1]} + {1'b0, b[W-1:1]} + W'(a[0] | b[0]);

   assign sovf_add = (a[W-1] == b[W-1]) && (sum_ext[W-1] != a[W-1]);
   assign sovf_sub = (a[W-1] != b[W-1]) && (dif_ext[W-1] != a[W-1]);

   always_comb begin
      res = '0;
      unique case (ctrl.op)
         PAL_ADD: begin
            res = sum_ext[W-1:0];
            if (ctrl.sat) begin
               if (ctrl.sgn) begin
                  if (sovf_add) res = sum_ext[W-1] ? SMAX : SMIN;
               end else if (sum_ext[W]) begin
                  res = UMAX;
               end
            end
         end
         PAL_SUB: begin
            res = dif_ext[W-1:0];
            if (ctrl.sat) begin
               if (ctrl.sgn) begin
                  if (sovf_sub) res = dif_ext[W-1] ? SMAX : SMIN;
               end else if (dif_ext[W]) begin
                  res = '0;
               end
            end
         end
         PAL_AVG: res = avg_val;
         default: res = '0;
      endcase
   end

   // lane-level invariants on the result
   always_comb begin
      if (ctrl.op == PAL_ADD && ctrl.sat && !ctrl.sgn) begin
         a_r5_uadd_floor: assert (res >= a && res >= b)
            else $error("R5 unsigned saturating add fell below an operand");
      end
      if (ctrl.op == PAL_SUB && ctrl.sat && !ctrl.sgn) begin
         a_r6_usub_ceiling: assert (res <= a)
            else $error("R6 unsigned saturating subtract exceeded minuend");
      end
      if (ctrl.op == PAL_AVG) begin
         a_r7_avg_between: assert ((res >= a || res >= b) && (res <= a || res <= b))
            else $error("R7 average outside operand range");
      end
   end

endmodule

// File: rtl/pal_slice.sv
module pal_slice
   import pal_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int W      = 8
) (
   input  pal_ctrl_t           ctrl,
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   output logic [DATA_W-1:0]   res
);

   localparam int LANES = DATA_W / W;

   if (W < PAL_MIN_LANE_W || (DATA_W % W) != 0) begin : g_bad_width
      $error("pal_slice: lane width must be >= 8 and divide the data width");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      pal_lane #(.W(W)) u_lane (
         .ctrl (ctrl),
         .a    (a[i*W +: W]),
         .b    (b[i*W +: W]),
         .res  (res[i*W +: W])
      );
   end

endmodule

// File: rtl/pal_top.sv
module pal_top
   import pal_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [1:0]        in_op,
   input  logic [1:0]        in_width,
   input  logic              in_sat,
   input  logic              in_signed,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result
);

   localparam int MAX_W = PAL_MIN_LANE_W << (PAL_NUM_WIDTHS - 1);

   if (DATA_W != MAX_W) begin : g_bad_data_w
      $error("pal_top: data width must equal the widest lane");
   end

   pal_ctrl_t         ctrl;
   logic [DATA_W-1:0] slice_res [PAL_NUM_WIDTHS];
   logic [DATA_W-1:0] sel_res;

   assign ctrl.op  = pal_op_e'(in_op);
   assign ctrl.sat = in_sat;
   assign ctrl.sgn = in_signed;

   for (genvar g = 0; g < PAL_NUM_WIDTHS; g++) begin : g_width
      pal_slice #(
         .DATA_W (DATA_W),
         .W      (PAL_MIN_LANE_W << g)
      ) u_slice (
         .ctrl (ctrl),
         .a    (in_a),
         .b    (in_b),
         .res  (slice_res[g])
      );
   end

   always_comb begin
      unique case (pal_width_e'(in_width))
         PAL_W8:  sel_res = slice_res[0];
         PAL_W16: sel_res = slice_res[1];
         PAL_W32: sel_res = slice_res[2];
         default: sel_res = slice_res[3];
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_result <= sel_res;
      end
   end

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid)
      else $error("R9 missing out_valid");

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid)
      else $error("R9 spurious out_valid");

   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_result))
      else $error("R9 result changed while idle");

   a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == 2'd3) |=> (out_result == '0))
      else $error("R8 reserved opcode gave nonzero result");

   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_valid && out_result == '0))
      else $error("R10 reset did not clear outputs");

endmodule

// File: tb/pal_top_test.sv
module pal_top_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = 2'd0;
   logic [1:0]  in_width = 2'd0;
   logic        in_sat = 1'b0;
   logic        in_signed = 1'b0;
   logic [63:0] in_a = '0;
   logic [63:0] in_b = '0;
   logic        out_valid;
   logic [63:0] out_result;

   int checks = 0;
   int errors = 0;
   bit started = 0;
   bit done = 0;

   logic        exp_valid = 1'b0;
   logic [63:0] exp_result = '0;
   string       exp_tag = "R10";

   always #5 clk = ~clk;

   pal_top uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
      .in_width(in_width), .in_sat(in_sat), .in_signed(in_signed),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
   );

   function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                         logic [1:0] wc, logic [1:0] op,
                                         logic sat, logic sgn);
      int w = 8 << wc;
      logic [63:0] out = '0;
      logic signed [67:0] mask = (68'sd1 <<< w) - 68'sd1;
      logic signed [67:0] smax = (68'sd1 <<< (w - 1)) - 68'sd1;
      logic signed [67:0] smin = -(68'sd1 <<< (w - 1));
      for (int l = 0; l < 64 / w; l++) begin
         logic signed [67:0] ua = ($signed({4'b0, a}) >>> (l * w)) & mask;
         logic signed [67:0] ub = ($signed({4'b0, b}) >>> (l * w)) & mask;
         logic signed [67:0] sa = ua[w-1] ? ua - (68'sd1 <<< w) : ua;
         logic signed [67:0] sb = ub[w-1] ? ub - (68'sd1 <<< w) : ub;
         logic signed [67:0] r;
         case (op)
            2'd0, 2'd1: begin
               if (!sat) r = (op == 2'd0) ? ua + ub : ua - ub;
               else if (sgn) begin
                  r = (op == 2'd0) ? sa + sb : sa - sb;
                  if (r > smax) r = smax;
                  if (r < smin) r = smin;
               end else if (op == 2'd0) begin
                  r = ua + ub;
                  if (r > mask) r = mask;
               end else begin
                  r = (ua < ub) ? 68'sd0 : ua - ub;
               end
            end
            2'd2: r = (ua + ub + 68'sd1) >>> 1;
            default: r = 68'sd0;
         endcase
         r = r & mask;
         out = out | (r[63:0] << (l * w));
      end
      return out;
   endfunction

   function automatic string tag_of(logic [1:0] op, logic sat, logic sgn);
      if (op == 2'd3) return "R8";
      if (op == 2'd2) return "R7";
      if (!sat) return "R1";
      if (sgn) return (op == 2'd0) ? "R3" : "R4";
      return (op == 2'd0) ? "R5" : "R6";
   endfunction

   // cycle model of the registered output
   always @(posedge clk) begin
      if (rst) begin
         exp_valid  <= 1'b0;
         exp_result <= '0;
         exp_tag    <= "R10";
      end else begin
         exp_valid <= in_valid;
         if (in_valid) begin
            exp_result <= model(in_a, in_b, in_width, in_op, in_sat, in_signed);
            exp_tag    <= {tag_of(in_op, in_sat, in_signed), "/R2"};
         end
      end
      started <= 1'b1;
   end

   // compare away from the active edge
   always @(negedge clk) begin
      if (started && !done) begin
         checks++;
         if (out_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s out_valid actual %0b expected %0b",
                     rst ? "R10" : "R9", out_valid, exp_valid);
         end
         checks++;
         if (out_result !== exp_result) begin
            errors++;
            $display("FAIL %s out_result actual %h expected %h",
                     exp_tag, out_result, exp_result);
         end
      end
   end

   task automatic issue(logic [63:0] a, logic [63:0] b, logic [1:0] wc,
                        logic [1:0] op, logic sat, logic sgn);
      in_valid  = 1'b1;
      in_a      = a;
      in_b      = b;
      in_width  = wc;
      in_op     = op;
      in_sat    = sat;
      in_signed = sgn;
      @(negedge clk);
      in_valid  = 1'b0;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         in_valid = 1'b0;
         in_a = {$urandom, $urandom};
         in_b = {$urandom, $urandom};
         in_op = 2'($urandom);
         @(negedge clk);
      end
   endtask

   function automatic logic [63:0] pick();
      case ($urandom % 7)
         0: return 64'h0;
         1: return '1;
         2: return 64'h8080_8080_8080_8080;
         3: return 64'h7f7f_7f7f_7f7f_7f7f;
         4: return 64'h8000_0000_8000_0000;
         5: return 64'h7fff_ffff_ffff_ffff;
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);   // R10 reset state compared each cycle
      rst = 1'b0;
      @(negedge clk);
      // R3 signed add clamps, 8-bit lanes, both directions in one word
      issue(64'h7f80_7f80_0102_7f80, 64'h0180_0101_fe01_7fff, 2'd0, 2'd0, 1'b1, 1'b1);
      // R4 signed subtract clamps at 16 bits
      issue(64'h8000_7fff_0005_8001, 64'h0001_ffff_0007_0002, 2'd1, 2'd1, 1'b1, 1'b1);
      // R5 unsigned add saturates at 32 and 64 bits
      issue(64'hffff_fff0_0000_0001, 64'h0000_0020_0000_0002, 2'd2, 2'd0, 1'b1, 1'b0);
      issue('1, 64'h1, 2'd3, 2'd0, 1'b1, 1'b0);
      // R6 unsigned subtract floors at zero
      issue(64'h0010_0003_0000_ffff, 64'h0011_0001_0001_fffe, 2'd1, 2'd1, 1'b1, 1'b0);
      issue(64'h5, 64'h6, 2'd3, 2'd1, 1'b1, 1'b0);
      // R1 wraparound with signed bit set but saturation off
      issue(64'h7f7f_7f7f_7f7f_7f7f, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 1'b0, 1'b1);
      issue(64'h0, 64'h1, 2'd3, 2'd1, 1'b0, 1'b0);
      // R7 average keeps the carry, sat/sign ignored
      issue('1, '1, 2'd3, 2'd2, 1'b1, 1'b1);
      issue(64'hff00_0102_ffff_0001, 64'hff01_0101_0001_0000, 2'd0, 2'd2, 1'b0, 1'b0);
      // R8 reserved opcode
      issue('1, '1, 2'd2, 2'd3, 1'b1, 1'b1);
      // R9 hold while idle with changing inputs
      idle(4);
      // back-to-back requests across widths (R2 lane independence)
      for (int wc = 0; wc < 4; wc++)
         issue(64'h00ff_7f80_0102_ff01, 64'h0101_0180_ff02_0101, 2'(wc), 2'd0, 1'b1, 1'b0);
      // R10 mid-run reset clears a nonzero result
      issue('1, 64'h0, 2'd0, 2'd0, 1'b0, 1'b0);
      rst = 1'b1;
      issue('1, '1, 2'd1, 2'd2, 1'b0, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      idle(1);
      // randomized extremes, with gaps
      for (int n = 0; n < 800; n++) begin
         issue(pick(), pick(), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
         if ($urandom % 5 == 0) idle(1 + $urandom % 3);
      end
      idle(2);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule